// File: doc/BRIEF.md
# Serial Byte Receiver with Break Parking

This block turns an asynchronous serial line into bytes. The line passes through a two-stage synchroniser. A receive state machine advances only on cycles where the tick enable is high, and a bit lasts eight ticks. When the receiver is idle, a low level on the line starts a frame. The first data bit is sampled twelve ticks after the start is seen, which is about the middle of bit 0. Each later bit is sampled eight ticks after the one before it. The block collects eight data bits, least-significant first, and then checks the stop position. A byte with a high stop bit goes into an eight-entry FIFO. The consumer reads that FIFO through a valid/ready port.

A frame with a low stop bit is treated as a framing error or a line break. No byte is stored and a sticky error flag is raised. The receiver then stays parked until the line goes high again, so a line held low cannot start a second, bogus frame.

The enable input mutes the receiver, for example while the local transmitter drives a shared wire. Back-pressure rules on the read port:
- A byte leaves the FIFO only on a cycle where valid and ready are both high.
- While valid is high and ready is low, the data is held unchanged.
- The receiver never waits for the consumer. A good byte that arrives while all eight entries are occupied is dropped and sets the overflow flag.

Top module: `serial_rx_top`

## Requirements
- R1: When the receiver is enabled and idle, a tick on which the synchronised line is low starts a frame. The line input passes through two flip-flops before it is used.
- R2: Bit 0 is sampled on the 12th tick after the start tick, and each following bit 8 ticks after the previous one. Received bits fill the byte LSB first (the first data bit is bit 0 of `rd_data_o`).
- R3: A frame whose stop sample, taken 8 ticks after bit 7, is high stores its byte in the FIFO. Bytes are read out in arrival order. A byte is removed only when `rd_valid_o` and `rd_ready_i` are both high, and `rd_data_o` stays stable while valid is high and ready is low.
- R4: A frame with a low stop sample stores no byte and sets `irq_err_o`.
- R5: After a low stop sample, the receiver does not start a new frame until the line has been seen high. A break held low therefore sets the error only once and produces no data.
- R6: The FIFO holds 8 bytes. A good byte that arrives while it is full is discarded, and `ovf_o` is set.
- R7: `irq_nempty_o` is high exactly when at least one byte is waiting.
- R8: `irq_err_o` and `ovf_o` stay set until a cycle with `err_clr_i` high clears them. A new event in the same cycle as the clear wins, and the flag stays set.
- R9: While `en_i` is low, the receiver returns to idle at the next clock and ignores the line, and the FIFO contents are left unchanged.
- R10: After reset the FIFO is empty and `rd_valid_o`, `irq_nempty_o`, `irq_err_o` and `ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | Oversampling tick enable, 8 per bit |
| en_i | input | 1 | Receiver enable; low mutes and resets the receiver to idle |
| rd_valid_o | output | 1 | A received byte is available |
| rd_ready_i | input | 1 | Consumer accepts the byte |
| rd_data_o | output | 8 | Oldest received byte |
| irq_nempty_o | output | 1 | FIFO holds at least one byte |
| irq_err_o | output | 1 | Sticky framing or break error |
| ovf_o | output | 1 | Sticky overflow, a good byte was dropped |
| err_clr_i | input | 1 | Clears both sticky flags |

## Verification
The checker verifies a set of rules on every cycle:
- Read data is held while valid is high and ready is low.
- A bad stop sets the error flag and never pushes a byte.
- The error flag stays set until it is cleared.
- Disabling the receiver parks it in idle.
- Overflow only rises after a push into a full FIFO.

The tick-accurate sample points, LSB-first assembly and arrival order can only be shown by the bench, which sends real frames and compares the bytes read out. The same holds for suppression of data during a held break, and for dropping exactly the ninth byte.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_DATA,
    RX_STOP,
    RX_PARK
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              line_i,
  output logic              push_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              bad_o,
  output logic              busy_o
);
  localparam int FIRST_WAIT = TICKS_PER_BIT + TICKS_PER_BIT / 2 - 1;
  localparam int CW         = $clog2(FIRST_WAIT + 1);
  localparam int BW         = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      push_o  <= 1'b0;
      bad_o   <= 1'b0;
    end else begin
      push_o <= 1'b0;
      bad_o  <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!line_i) begin
              state_q <= RX_DATA;
              cnt_q   <= CW'(FIRST_WAIT);
              bit_q   <= '0;
            end
          end
          RX_DATA: begin
            if (cnt_q == '0) begin
              shift_q <= {line_i, shift_q[DATA_W-1:1]};
              cnt_q   <= CW'(TICKS_PER_BIT - 1);
              if (bit_q == BW'(DATA_W - 1)) state_q <= RX_STOP;
              else                          bit_q   <= bit_q + 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == '0) begin
              if (line_i) begin
                push_o  <= 1'b1;
                state_q <= RX_IDLE;
              end else begin
                bad_o   <= 1'b1;
                state_q <= RX_PARK;
              end
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          RX_PARK: begin
            if (line_i) state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign byte_o = shift_q;
  assign busy_o = (state_q != RX_IDLE);
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             full_o,
  output logic             drop_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wp_q, rp_q;
  logic [AW:0]      used;
  logic             wr_en, rd_en;

  assign used    = wp_q - rp_q;
  assign full_o  = (used == (AW+1)'(DEPTH));
  assign valid_o = (used != '0);
  assign wr_en   = push_i && !full_o;
  assign drop_o  = push_i && full_o;
  assign rd_en   = valid_o && ready_i;
  assign rdata_o = mem_q[rp_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + 1'b1;
      if (rd_en) rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wp_q[AW-1:0]] <= wdata_i;
  end
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 8,
  parameter int FIFO_DEPTH    = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              tick_i,
  input  logic              en_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_nempty_o,
  output logic              irq_err_o,
  output logic              ovf_o,
  input  logic              err_clr_i
);
  logic              line_s;
  logic              core_push, core_bad, core_busy;
  logic [DATA_W-1:0] core_byte;
  logic              fifo_full, fifo_drop;
  logic              err_q, ovf_q;

  serial_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
  );

  serial_rx_core #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i),
    .line_i(line_s), .push_o(core_push), .byte_o(core_byte),
    .bad_o(core_bad), .busy_o(core_busy)
  );

  serial_rx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(core_push), .wdata_i(core_byte),
    .full_o(fifo_full), .drop_o(fifo_drop), .valid_o(rd_valid_o),
    .ready_i(rd_ready_i), .rdata_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      err_q <= core_bad  | (err_q & ~err_clr_i);
      ovf_q <= fifo_drop | (ovf_q & ~err_clr_i);
    end
  end

  assign irq_err_o    = err_q;
  assign ovf_o        = ovf_q;
  assign irq_nempty_o = rd_valid_o;
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_err_o,
  input logic              ovf_o,
  input logic              err_clr_i,
  input logic              core_push,
  input logic              core_bad,
  input logic              core_busy,
  input logic              fifo_full
);
  AST_HOLD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o)); // R3
  AST_BAD_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_bad |-> !core_push); // R4
  AST_BAD_SETS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_bad |=> irq_err_o); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_err_o && !err_clr_i |=> irq_err_o); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !err_clr_i |=> ovf_o); // R8
  AST_OVF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(core_push && fifo_full)); // R6
  AST_MUTE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !core_busy); // R9
endmodule

bind serial_rx_top serial_rx_checker #(.DATA_W(DATA_W)) u_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .rd_valid_o(rd_valid_o),
  .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o), .irq_err_o(irq_err_o),
  .ovf_o(ovf_o), .err_clr_i(err_clr_i), .core_push(core_push),
  .core_bad(core_bad), .core_busy(core_busy), .fifo_full(fifo_full)
);

// File: tb/serial_rx_top_tb.sv
module serial_rx_top_tb_top;
  localparam int BITCLK = 16;  // tick every 2 clocks, 8 ticks per bit

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       en_i = 1'b1;
  logic       rd_ready_i = 1'b0;
  logic       err_clr_i = 1'b0;
  logic       rd_valid_o, irq_nempty_o, irq_err_o, ovf_o;
  logic [7:0] rd_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  serial_rx_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .tick_i(tick_i),
    .en_i(en_i), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .rd_data_o(rd_data_o), .irq_nempty_o(irq_nempty_o),
    .irq_err_o(irq_err_o), .ovf_o(ovf_o), .err_clr_i(err_clr_i)
  );

  always #2 clk_i = ~clk_i;

  initial begin
    forever begin
      @(negedge clk_i);
      tick_i = ~tick_i;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // Monitor: pops expected bytes on each handshake (R2, R3)
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o && rd_ready_i) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R3: actual %0h expected none", rd_data_o);
      end else begin
        check("R2 R3 byte", rd_data_o, exp_q.pop_front());
      end
    end
  end

  // Driver: one frame; predicts FIFO outcome when expected to be received
  task automatic send_frame(input logic [7:0] b, input bit stop_ok, input bit expect_rx);
    if (expect_rx && stop_ok && exp_q.size() < 8) exp_q.push_back(b);
    line_i = 1'b0; wait_clk(BITCLK);
    for (int i = 0; i < 8; i++) begin
      line_i = b[i]; wait_clk(BITCLK);
    end
    line_i = stop_ok; wait_clk(BITCLK);
    line_i = 1'b1; wait_clk(2 * BITCLK);
  endtask

  initial begin
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(2);
    check("R10 valid", rd_valid_o, 0);
    check("R10 nempty", irq_nempty_o, 0);
    check("R10 err", irq_err_o, 0);
    check("R10 ovf", ovf_o, 0);

    // R1 R2 R3: several patterns, streaming
    rd_ready_i = 1'b1;
    send_frame(8'hA5, 1, 1);
    send_frame(8'h3C, 1, 1);
    send_frame(8'h01, 1, 1);
    send_frame(8'h80, 1, 1);
    send_frame(8'hFF, 1, 1);
    send_frame(8'h00, 1, 1);
    wait_clk(4);
    check("R1 R3 all received", exp_q.size(), 0);

    // R7 and back-pressure hold
    rd_ready_i = 1'b0;
    send_frame(8'h5A, 1, 1);
    check("R7 nempty high", irq_nempty_o, 1);
    check("R3 data held", rd_data_o, 8'h5A);
    wait_clk(10);
    check("R3 still held", rd_data_o, 8'h5A);
    rd_ready_i = 1'b1;
    wait_clk(3);
    check("R7 nempty low", irq_nempty_o, 0);

    // R4 bad stop
    send_frame(8'h77, 0, 1);
    check("R4 err set", irq_err_o, 1);
    check("R4 no data", rd_valid_o, 0);

    // R5 break held low, clear while low: no re-trigger
    line_i = 1'b0;
    wait_clk(10 * BITCLK);
    check("R8 err sticky", irq_err_o, 1);
    err_clr_i = 1'b1; wait_clk(1); err_clr_i = 1'b0;
    wait_clk(20 * BITCLK);
    check("R5 no restart during break", irq_err_o, 0);
    check("R5 no data during break", rd_valid_o, 0);
    line_i = 1'b1;
    wait_clk(2 * BITCLK);
    send_frame(8'h42, 1, 1);
    wait_clk(4);
    check("R5 recovered", exp_q.size(), 0);

    // R6 overflow
    rd_ready_i = 1'b0;
    for (int k = 0; k < 9; k++) send_frame(8'h10 + 8'(k), 1, 1);
    check("R6 ovf set", ovf_o, 1);
    check("R6 nempty", irq_nempty_o, 1);
    rd_ready_i = 1'b1;
    wait_clk(20);
    check("R6 eight drained", exp_q.size(), 0);
    check("R6 empty", rd_valid_o, 0);
    err_clr_i = 1'b1; wait_clk(1); err_clr_i = 1'b0;
    check("R8 ovf cleared", ovf_o, 0);

    // R9 muted frame ignored
    en_i = 1'b0;
    send_frame(8'h99, 1, 0);
    check("R9 muted no data", rd_valid_o, 0);
    // R9 disable mid-frame
    en_i = 1'b1;
    line_i = 1'b0; wait_clk(BITCLK);
    line_i = 1'b1; wait_clk(3 * BITCLK);
    en_i = 1'b0;
    wait_clk(10 * BITCLK);
    en_i = 1'b1;
    wait_clk(2 * BITCLK);
    check("R9 aborted no data", rd_valid_o, 0);
    check("R9 aborted no err", irq_err_o, 0);
    send_frame(8'h66, 1, 1);
    wait_clk(4);
    check("R9 resumes", exp_q.size(), 0);

    summary();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule